// File: doc/BRIEF.md
# On-Screen Display Position Timing

This block places a text window inside a monitor raster. It follows the horizontal and vertical sync inputs and keeps a dot count since the end of each horizontal sync and a line count since the start of each vertical sync. It compares both counts against programmable start positions and raises a display-active flag over a grid of character cells. Alongside the flag it gives the character column, the dot inside the cell, the font line and the character row, which a later font and colour stage uses to fetch and paint pixels.

Cells are 12 dots wide and 18 font lines tall. Each font line can be repeated on 1 to 4 consecutive scan lines to make taller characters. Blank scan lines can be placed between character rows. Dots are counted on clock cycles that carry a dot-clock enable. Both sync inputs are asynchronous and pass through a two-flop synchronizer. Each has its own active-level select.

None of the outputs uses a handshake. The indices are plain registered values that follow the raster, and the downstream stage samples them on its own dot enables. It has no way to apply back-pressure, so there is none to state.

Top module: `osd_pos_timing`

## Requirements
- R1: `hs_pol`/`vs_pol` set the active level of each sync input (1 = active high, 0 = active low). A sync "onset" is the move of the synchronized input into its active level. The block reacts to an onset on the third clock edge after the input pin changes.
- R2: The dot position t counts the clock edges that sample `dot_en` = 1 while horizontal sync is inactive. It restarts at 0 on each horizontal onset. `dot_en` has no effect while horizontal sync is active. Dot outputs update on the edge that takes the tick.
- R3: Scan line k is the k-th horizontal onset after a vertical onset, counting from 0. A vertical onset clears the vertical window.
- R4: Horizontally, the window covers dots t with 4·`h_start` ≤ t < 4·`h_start` + 12·COLS.
- R5: Inside the window, `col_idx` = (t − 4·`h_start`) / 12 and `dot_idx` = (t − 4·`h_start`) mod 12, so `dot_idx` stays in 0..11.
- R6: The vertical window begins on line 4·`v_start`. If the frame has fewer lines than that, the frame shows no window at all.
- R7: With rep = `char_height` + 1 (encoding 0..3 gives 1..4 repeats) and rel = k − 4·`v_start`, `font_line` = (rel mod pitch) / rep, which stays in 0..17.
- R8: pitch = 18·rep + 4·`row_gap`. Each character row is followed by 4·`row_gap` blank lines. `row_idx` = rel / pitch. After ROWS rows the window stays off until the next vertical onset.
- R9: `row_adv` is a one-cycle pulse on the horizontal onset of the first line of each character row (rel mod pitch = 0 and rel / pitch < ROWS). It occurs on no other line.
- R10: After reset, `disp_act`, `row_adv` and all index outputs are 0.
- R11: `disp_act` is 1 only when both the horizontal and the vertical conditions hold, and the line is not one of the blank spacing lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_in | input | 1 | Horizontal sync, asynchronous |
| vsync_in | input | 1 | Vertical sync, asynchronous |
| hs_pol | input | 1 | Horizontal sync active level |
| vs_pol | input | 1 | Vertical sync active level |
| dot_en | input | 1 | One dot per enabled cycle |
| h_start | input | 6 | Horizontal start, in units of 4 dots |
| v_start | input | 6 | Vertical start, in units of 4 lines |
| char_height | input | 2 | Line repeats per font line, minus 1 |
| row_gap | input | 2 | Blank lines between rows, in units of 4 |
| disp_act | output | 1 | Display window active for the current dot |
| col_idx | output | CW | Character column |
| dot_idx | output | 4 | Dot inside the cell, 0..11 |
| font_line | output | 5 | Font line, 0..17 |
| row_idx | output | RW | Character row |
| row_adv | output | 1 | Pulse at the start of each character row |

## Verification
The hardest situation to reach is the interplay of the vertical sequencing rules. These are the last font line of a repeated line group, the move into the blank spacing lines, the return from them into the next row, and the cut-off after the final row. All of them have to occur with the horizontal window landing at the right dot.

The stimulus reaches these cases by running whole frames. Each frame has a random start position, height mode and spacing, and enough lines to pass every row and gap. `dot_en` is thinned at random, and it is toggled during the sync pulse to show that it has no effect there.

Directed frames add the far right start position, a start line past the end of a short frame, and both sync polarities.

// File: rtl/osd_pos_pkg.sv
package osd_pos_pkg;
  localparam int CELL_W   = 12;
  localparam int CELL_H   = 18;
  localparam int STEP_LG  = 2;
  localparam int POS_W    = 6;
endpackage

// File: rtl/osd_sync_edge.sv
module osd_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic pol,
  output logic act,
  output logic onset
);
  logic [1:0] sr;
  logic       act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= 2'b00;
      act_q <= 1'b1;
    end else begin
      sr    <= {sr[0], sync_in};
      act_q <= act;
    end
  end

  assign act   = pol ? sr[1] : ~sr[1];
  assign onset = act & ~act_q;

  AST_ONSET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    onset |=> !onset); // R1
endmodule

// File: rtl/osd_hwin.sv
module osd_hwin
  import osd_pos_pkg::*;
#(
  parameter int COLS = 8,
  parameter int HCW  = 10,
  parameter int CW   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_act,
  input  logic             hs_on,
  input  logic             dot_en,
  input  logic [POS_W-1:0] h_start,
  output logic             hwin,
  output logic [CW-1:0]    col,
  output logic [3:0]       dot
);
  logic [HCW-1:0] hcnt;
  logic [HCW-1:0] hbase;
  logic           tick;

  assign hbase = HCW'({h_start, {STEP_LG{1'b0}}});
  assign tick  = dot_en & ~hs_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      hwin <= 1'b0;
      col  <= '0;
      dot  <= '0;
    end else if (hs_on) begin
      hcnt <= '0;
      hwin <= 1'b0;
      col  <= '0;
      dot  <= '0;
    end else if (tick) begin
      if (hcnt != '1) hcnt <= hcnt + 1'b1;
      if (hcnt == hbase) begin
        hwin <= 1'b1;
        col  <= '0;
        dot  <= '0;
      end else if (hwin) begin
        if (dot == 4'(CELL_W - 1)) begin
          dot <= '0;
          if (col == CW'(COLS - 1)) hwin <= 1'b0;
          else col <= col + 1'b1;
        end else begin
          dot <= dot + 1'b1;
        end
      end
    end
  end

  AST_DOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dot <= 4'(CELL_W - 1)); // R5
  AST_HS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hs_on |=> !hwin); // R2
  AST_HOLD_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_act && !hs_on) |=> ($stable(dot) && $stable(col) && $stable(hwin))); // R2
endmodule

// File: rtl/osd_vwin.sv
module osd_vwin
  import osd_pos_pkg::*;
#(
  parameter int ROWS = 2,
  parameter int VCW  = 10,
  parameter int RW   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vs_on,
  input  logic             hs_on,
  input  logic [POS_W-1:0] v_start,
  input  logic [1:0]       char_height,
  input  logic [1:0]       row_gap,
  output logic             vwin,
  output logic [4:0]       fline,
  output logic [RW-1:0]    row,
  output logic             row_adv
);
  logic [VCW-1:0] vcnt;
  logic [VCW-1:0] vbase;
  logic           vact;
  logic           in_gap;
  logic [1:0]     rep_cnt;
  logic [3:0]     gap_cnt;
  logic [3:0]     gap_len;

  assign vbase   = VCW'({v_start, {STEP_LG{1'b0}}});
  assign gap_len = {row_gap, 2'b00};
  assign vwin    = vact & ~in_gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt    <= '0;
      vact    <= 1'b0;
      in_gap  <= 1'b0;
      rep_cnt <= '0;
      fline   <= '0;
      gap_cnt <= '0;
      row     <= '0;
      row_adv <= 1'b0;
    end else if (vs_on) begin
      vcnt    <= '0;
      vact    <= 1'b0;
      in_gap  <= 1'b0;
      row_adv <= 1'b0;
    end else if (hs_on) begin
      row_adv <= 1'b0;
      if (vcnt != '1) vcnt <= vcnt + 1'b1;
      if (vcnt == vbase) begin
        vact    <= 1'b1;
        in_gap  <= 1'b0;
        rep_cnt <= '0;
        fline   <= '0;
        gap_cnt <= '0;
        row     <= '0;
        row_adv <= 1'b1;
      end else if (vact) begin
        if (in_gap) begin
          if (gap_cnt == gap_len - 1'b1) begin
            in_gap  <= 1'b0;
            row     <= row + 1'b1;
            fline   <= '0;
            rep_cnt <= '0;
            row_adv <= 1'b1;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end else if (rep_cnt == char_height) begin
          rep_cnt <= '0;
          if (fline == 5'(CELL_H - 1)) begin
            fline <= '0;
            if (row == RW'(ROWS - 1)) begin
              vact <= 1'b0;
            end else if (gap_len == 4'd0) begin
              row     <= row + 1'b1;
              row_adv <= 1'b1;
            end else begin
              in_gap  <= 1'b1;
              gap_cnt <= '0;
            end
          end else begin
            fline <= fline + 1'b1;
          end
        end else begin
          rep_cnt <= rep_cnt + 1'b1;
        end
      end
    end else begin
      row_adv <= 1'b0;
    end
  end

  AST_FLINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fline <= 5'(CELL_H - 1)); // R7
  AST_VS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    vs_on |=> !vwin); // R3
  AST_ADV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    row_adv |=> !row_adv); // R9
  AST_ADV_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    row_adv |-> $past(hs_on)); // R9
endmodule

// File: rtl/osd_pos_timing.sv
module osd_pos_timing
  import osd_pos_pkg::*;
#(
  parameter  int COLS = 8,
  parameter  int ROWS = 2,
  parameter  int HCW  = 10,
  parameter  int VCW  = 10,
  localparam int CW   = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsync_in,
  input  logic          vsync_in,
  input  logic          hs_pol,
  input  logic          vs_pol,
  input  logic          dot_en,
  input  logic [5:0]    h_start,
  input  logic [5:0]    v_start,
  input  logic [1:0]    char_height,
  input  logic [1:0]    row_gap,
  output logic          disp_act,
  output logic [CW-1:0] col_idx,
  output logic [3:0]    dot_idx,
  output logic [4:0]    font_line,
  output logic [RW-1:0] row_idx,
  output logic          row_adv
);
  logic hs_act, hs_on, vs_act, vs_on;
  logic hwin, vwin;

  osd_sync_edge u_hs (
    .clk(clk), .rst_n(rst_n), .sync_in(hsync_in), .pol(hs_pol),
    .act(hs_act), .onset(hs_on)
  );

  osd_sync_edge u_vs (
    .clk(clk), .rst_n(rst_n), .sync_in(vsync_in), .pol(vs_pol),
    .act(vs_act), .onset(vs_on)
  );

  osd_hwin #(.COLS(COLS), .HCW(HCW), .CW(CW)) u_hwin (
    .clk(clk), .rst_n(rst_n), .hs_act(hs_act), .hs_on(hs_on),
    .dot_en(dot_en), .h_start(h_start),
    .hwin(hwin), .col(col_idx), .dot(dot_idx)
  );

  osd_vwin #(.ROWS(ROWS), .VCW(VCW), .RW(RW)) u_vwin (
    .clk(clk), .rst_n(rst_n), .vs_on(vs_on), .hs_on(hs_on),
    .v_start(v_start), .char_height(char_height), .row_gap(row_gap),
    .vwin(vwin), .fline(font_line), .row(row_idx), .row_adv(row_adv)
  );

  assign disp_act = hwin & vwin;

  AST_VS_KILLS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    vs_on |=> !disp_act); // R11
  AST_NOT_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_act && !hs_on && !vs_act) |=> ($stable(disp_act) || !disp_act)); // R11
endmodule

// File: tb/osd_pos_timing_bench.sv
`timescale 1ns/1ps
module osd_pos_timing_bench;
  localparam int COLS = 8;
  localparam int ROWS = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync_in = 1'b0, vsync_in = 1'b0;
  logic       hs_pol = 1'b1, vs_pol = 1'b1;
  logic       dot_en = 1'b0;
  logic [5:0] h_start = '0, v_start = '0;
  logic [1:0] char_height = '0, row_gap = '0;
  logic       disp_act, row_adv;
  logic [2:0] col_idx;
  logic [3:0] dot_idx;
  logic [4:0] font_line;
  logic [0:0] row_idx;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  osd_pos_timing #(.COLS(COLS), .ROWS(ROWS)) u_osd_pos_timing (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .hs_pol(hs_pol), .vs_pol(vs_pol), .dot_en(dot_en),
    .h_start(h_start), .v_start(v_start), .char_height(char_height),
    .row_gap(row_gap), .disp_act(disp_act), .col_idx(col_idx),
    .dot_idx(dot_idx), .font_line(font_line), .row_idx(row_idx),
    .row_adv(row_adv)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int rep_f();
    return int'(char_height) + 1;
  endfunction
  function automatic int pitch_f();
    return 18 * rep_f() + 4 * int'(row_gap);
  endfunction
  function automatic int rel_f(input int k);
    return k - 4 * int'(v_start);
  endfunction
  function automatic bit v_on(input int k);
    int rel = rel_f(k);
    if (rel < 0) return 1'b0;
    return (rel / pitch_f() < ROWS) && (rel % pitch_f() < 18 * rep_f());
  endfunction
  function automatic bit v_adv(input int k);
    int rel = rel_f(k);
    if (rel < 0) return 1'b0;
    return (rel % pitch_f() == 0) && (rel / pitch_f() < ROWS);
  endfunction
  function automatic bit h_on(input int t);
    int hb = 4 * int'(h_start);
    return (t >= hb) && (t < hb + 12 * COLS);
  endfunction

  task automatic do_line(input int k, input int nticks);
    int adv = 0;
    hsync_in = hs_pol;
    dot_en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (i >= 3) dot_en = 1'($urandom % 2);
      step();
      if (row_adv) adv++;
    end
    hsync_in = ~hs_pol;
    dot_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      if (row_adv) adv++;
    end
    chk("R3 R9 row_adv count", adv, int'(v_adv(k)));
    for (int t = 0; t < nticks; ) begin
      bit en = ($urandom % 4) != 0;
      dot_en = en;
      step();
      if (en) begin
        bit e = v_on(k) && h_on(t);
        int off = t - 4 * int'(h_start);
        chk("R1 R4 R6 R11 disp_act", int'(disp_act), int'(e));
        if (e) begin
          chk("R2 R5 col_idx", int'(col_idx), off / 12);
          chk("R2 R5 dot_idx", int'(dot_idx), off % 12);
          chk("R3 R7 font_line", int'(font_line),
              (rel_f(k) % pitch_f()) / rep_f());
          chk("R8 row_idx", int'(row_idx), rel_f(k) / pitch_f());
        end
        t++;
      end
    end
    dot_en = 1'b0;
  endtask

  task automatic frame(input bit hp, input bit vp, input int hs, input int vs,
                       input int ch, input int gp, input int nlines, input int nticks);
    hs_pol = hp; vs_pol = vp;
    hsync_in = ~hp; vsync_in = ~vp;
    h_start = 6'(hs); v_start = 6'(vs);
    char_height = 2'(ch); row_gap = 2'(gp);
    repeat (4) step();
    vsync_in = vp;
    repeat (4) step();
    vsync_in = ~vp;
    repeat (4) step();
    for (int k = 0; k < nlines; k++) do_line(k, nticks);
  endtask

  function automatic int lines_for(input int vs, input int ch, input int gp);
    return 4 * vs + ROWS * (18 * (ch + 1) + 4 * gp) + 2;
  endfunction

  initial begin
    void'($urandom(32'd1234));
    hsync_in = 1'b0; vsync_in = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    chk("R10 disp_act", int'(disp_act), 0);
    chk("R10 row_adv", int'(row_adv), 0);
    chk("R10 col_idx", int'(col_idx), 0);
    chk("R10 dot_idx", int'(dot_idx), 0);
    chk("R10 font_line", int'(font_line), 0);
    chk("R10 row_idx", int'(row_idx), 0);
    // directed: origin, single height, no gap, active-high h, active-low v
    frame(1'b1, 1'b0, 0, 0, 0, 0, lines_for(0, 0, 0), 12 * COLS + 2);
    // directed: start beyond a short frame, no window at all (R6)
    frame(1'b0, 1'b1, 0, 63, 1, 1, 30, 20);
    // directed: far right start, active-low both
    frame(1'b0, 1'b0, 63, 0, 0, 1, lines_for(0, 0, 1), 4 * 63 + 12 * COLS + 2);
    // random frames
    for (int f = 0; f < 3; f++) begin
      int hs = int'($urandom % 4);
      int vs = int'($urandom % 4);
      int ch = (f == 0) ? 3 : int'($urandom % 4);
      int gp = (f == 0) ? 3 : int'($urandom % 4);
      frame(1'($urandom % 2), 1'($urandom % 2), hs, vs, ch, gp,
            lines_for(vs, ch, gp), 4 * hs + 12 * COLS + 2);
    end
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule